// File: doc/BRIEF.md
# Settable Time-of-Day and Day Counter

This block keeps the time of day as hours, minutes and seconds, and a day-of-month count from 0 to 31. It runs on the fast system clock. A one-cycle enable tick, produced elsewhere once per second, advances it. While it runs, each tick adds a second. Seconds carry into minutes, minutes carry into hours, and the end of the day advances the day count.

To set the time, the user raises the halt switch, which freezes every field. The user then uses the level switches to choose one field and presses an increment button, which steps that field by one per press. The button is an asynchronous input. The block synchronises it and reacts to its rising edge, so a press held for many cycles counts once. A format switch selects how the display hour is shown: as a 0 to 23 value, or folded into the 0 to 11 range.

Top module: `tod_date_keeper`

## Requirements
- R1: With halt low, each cycle with the tick high adds one to the seconds. From 59 the seconds go to 0, and minutes advance by one in the same cycle.
- R2: Minutes run from 0 to 59 and carry into hours when they wrap on a tick. Hours run from 0 to 23 and wrap to 0.
- R3: When the time wraps from 23:59:59 to 00:00:00 on a tick, the day count advances by one, and it wraps from 31 to 0.
- R4: While halt is high, ticks are ignored: seconds never change, and minutes, hours and day change only through a manual step.
- R5: With halt high, settime high and hour-select high, each press adds one to the hour and wraps from 23 to 0. No other field changes.
- R6: With halt high, settime high and minute-select high (hour-select low), each press adds one to the minute and wraps from 59 to 0. It does not carry into hours.
- R7: When hour-select and minute-select are both high during set, a press steps only the hour.
- R8: With halt high and day-select high, and neither hour-select nor minute-select active under settime, each press adds one to the day and wraps from 31 to 0.
- R9: A press held for several cycles steps a field exactly once. A press has no effect when halt is low, and none when no field is selected.
- R10: When the format switch is 1, the display hour equals the hour. When it is 0, the display hour is the hour modulo 12 (0 to 11).
- R11: An active-low reset clears hours, minutes, seconds and day to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sec_tick | input | 1 | One-cycle pulse once per second |
| halt_sw | input | 1 | Freezes the time and enables manual stepping |
| settime_sw | input | 1 | Enables hour and minute stepping while halted |
| pick_hr | input | 1 | Selects the hour for stepping |
| pick_min | input | 1 | Selects the minute for stepping |
| pick_day | input | 1 | Selects the day count for stepping |
| fmt24 | input | 1 | 1: display hour 0 to 23; 0: display hour 0 to 11 |
| bump_btn | input | 1 | Asynchronous increment button |
| hours_o | output | 5 | Binary hour, 0 to 23 |
| minutes_o | output | 6 | Binary minute, 0 to 59 |
| seconds_o | output | 6 | Binary second, 0 to 59 |
| day_o | output | 5 | Binary day count, 0 to 31 |
| disp_hr_o | output | 5 | Hour in the selected display format |

## Verification
A wrong carry or wrap value in a counter shows at the outputs in the cycle after the tick that crosses it. The boundary cases are 59 seconds, 23:59:59 and day 31, and the bench drives all three. A fault in the press path, such as a lost synchroniser stage, a level-sensitive pulse or a wrong select priority, shows as a field that moves by the wrong amount or in the wrong place. That shows within three cycles of a press. The bench steps each field across its wrap and compares every output after each group of presses or ticks.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int SEC_MOD = 60;
  localparam int MIN_MOD = 60;
  localparam int HR_MOD  = 24;
  localparam int DAY_MOD = 32;
  localparam int SEC_W   = $clog2(SEC_MOD);
  localparam int MIN_W   = $clog2(MIN_MOD);
  localparam int HR_W    = $clog2(HR_MOD);
  localparam int DAY_W   = $clog2(DAY_MOD);
  localparam int HALF_DAY_HR = HR_MOD / 2;
endpackage

// File: rtl/tod_bump_sync.sv
module tod_bump_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= btn_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= 1'b0;
      else        chain_q[g] <= chain_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~prev_q;

  // R9: a press yields a pulse of a single cycle
  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tod_wrap_ctr.sv
module tod_wrap_ctr #(
  parameter int MOD = 60,
  localparam int W = $clog2(MOD)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  output logic [W-1:0] val_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] TOP = W'(MOD - 1);

  logic [W-1:0] val_q, val_d;
  logic         at_top;

  assign at_top = (val_q == TOP);

  always_comb begin
    val_d = val_q;
    if (step_i) val_d = at_top ? '0 : val_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_d;
  end

  assign val_o  = val_q;
  assign wrap_o = step_i & at_top;

  // R2: a counter never leaves its range
  p_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    val_q <= TOP);
endmodule

// File: rtl/tod_hour_view.sv
module tod_hour_view #(
  parameter int HALF = 12,
  parameter int W    = 5
) (
  input  logic [W-1:0] hr_i,
  input  logic         fmt24_i,
  output logic [W-1:0] disp_o
);
  localparam logic [W-1:0] HALF_V = W'(HALF);

  always_comb begin
    if (fmt24_i)             disp_o = hr_i;
    else if (hr_i >= HALF_V) disp_o = hr_i - HALF_V;
    else                     disp_o = hr_i;
  end
endmodule

// File: rtl/tod_date_keeper.sv
module tod_date_keeper
  import tod_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_tick,
  input  logic             halt_sw,
  input  logic             settime_sw,
  input  logic             pick_hr,
  input  logic             pick_min,
  input  logic             pick_day,
  input  logic             fmt24,
  input  logic             bump_btn,
  output logic [HR_W-1:0]  hours_o,
  output logic [MIN_W-1:0] minutes_o,
  output logic [SEC_W-1:0] seconds_o,
  output logic [DAY_W-1:0] day_o,
  output logic [HR_W-1:0]  disp_hr_o
);
  logic bump_rise;
  logic run_tick;
  logic set_hr, set_min, set_day;
  logic sec_step, min_step, hr_step, day_step;
  logic sec_wrap, min_wrap, hr_wrap, day_wrap;

  tod_bump_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .btn_i(bump_btn), .rise_o(bump_rise));

  // Step enables: run path and manual path are mutually exclusive by halt
  always_comb begin
    run_tick = sec_tick & ~halt_sw;
    set_hr   = bump_rise & halt_sw & settime_sw & pick_hr;
    set_min  = bump_rise & halt_sw & settime_sw & pick_min & ~pick_hr;
    set_day  = bump_rise & halt_sw & pick_day
             & ~(settime_sw & (pick_hr | pick_min));
    sec_step = run_tick;
    min_step = (sec_wrap & run_tick) | set_min;
    hr_step  = (min_wrap & run_tick) | set_hr;
    day_step = (hr_wrap  & run_tick) | set_day;
  end

  tod_wrap_ctr #(.MOD(SEC_MOD)) u_sec (
    .clk(clk), .rst_n(rst_n), .step_i(sec_step), .val_o(seconds_o), .wrap_o(sec_wrap));
  tod_wrap_ctr #(.MOD(MIN_MOD)) u_min (
    .clk(clk), .rst_n(rst_n), .step_i(min_step), .val_o(minutes_o), .wrap_o(min_wrap));
  tod_wrap_ctr #(.MOD(HR_MOD)) u_hr (
    .clk(clk), .rst_n(rst_n), .step_i(hr_step), .val_o(hours_o), .wrap_o(hr_wrap));
  tod_wrap_ctr #(.MOD(DAY_MOD)) u_day (
    .clk(clk), .rst_n(rst_n), .step_i(day_step), .val_o(day_o), .wrap_o(day_wrap));

  tod_hour_view #(.HALF(HALF_DAY_HR), .W(HR_W)) u_view (
    .hr_i(hours_o), .fmt24_i(fmt24), .disp_o(disp_hr_o));

  // R1: second 59 plus a running tick returns to zero and advances minutes
  p_sec_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !halt_sw && seconds_o == SEC_W'(SEC_MOD-1))
      |=> (seconds_o == '0) && (minutes_o != $past(minutes_o)));

  // R3: end of day advances the day count
  p_day_roll_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !halt_sw && hours_o == HR_W'(HR_MOD-1)
     && minutes_o == MIN_W'(MIN_MOD-1) && seconds_o == SEC_W'(SEC_MOD-1))
      |=> (hours_o == '0) && (day_o == DAY_W'($past(day_o) + 1'b1)));

  // R4: seconds are frozen while halted
  p_halt_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    halt_sw |=> $stable(seconds_o));

  // R9: without a button edge nothing moves while halted
  p_no_edge_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_sw && !bump_rise) |=> ($stable(hours_o) && $stable(minutes_o) && $stable(day_o)));

  // R7: at most one field stepped per press
  p_one_field_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_hr, set_min, set_day}));

  // R10: folded display hour stays below twelve
  p_fold_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fmt24 |-> (disp_hr_o < HR_W'(HALF_DAY_HR)));

  // R11: fields read zero while reset is held
  p_reset_clear_r11: assert property (@(posedge clk)
    !rst_n |-> (hours_o == '0 && minutes_o == '0 && seconds_o == '0 && day_o == '0));
endmodule

// File: tb/tod_date_keeper_bench.sv
module tod_date_keeper_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic sec_tick, halt_sw, settime_sw, pick_hr, pick_min, pick_day, fmt24, bump_btn;
  logic [4:0] hours_o, day_o, disp_hr_o;
  logic [5:0] minutes_o, seconds_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  tod_date_keeper u_tod_date_keeper (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .halt_sw(halt_sw),
    .settime_sw(settime_sw), .pick_hr(pick_hr), .pick_min(pick_min),
    .pick_day(pick_day), .fmt24(fmt24), .bump_btn(bump_btn),
    .hours_o(hours_o), .minutes_o(minutes_o), .seconds_o(seconds_o),
    .day_o(day_o), .disp_hr_o(disp_hr_o));

  // vector: op(1: 0 tick, 1 press) | sw{halt,set,hr,min,day}(5) | reps(8) | req(4)
  //         | exp hour(5) | exp min(6) | exp sec(6) | exp day(5)
  localparam int VW = 40;
  localparam int NV = 17;
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 5'b00000, 8'd5,  4'd1,  5'd0,  6'd0,  6'd5, 5'd0},  // R1 count
    {1'b0, 5'b00000, 8'd55, 4'd1,  5'd0,  6'd1,  6'd0, 5'd0},  // R1 wrap and carry
    {1'b0, 5'b10000, 8'd3,  4'd4,  5'd0,  6'd1,  6'd0, 5'd0},  // R4 ticks ignored
    {1'b1, 5'b11100, 8'd23, 4'd5,  5'd23, 6'd1,  6'd0, 5'd0},  // R5 hour step
    {1'b1, 5'b11110, 8'd1,  4'd7,  5'd0,  6'd1,  6'd0, 5'd0},  // R7 hour wins, R5 wrap
    {1'b1, 5'b11100, 8'd23, 4'd5,  5'd23, 6'd1,  6'd0, 5'd0},  // R5
    {1'b1, 5'b11010, 8'd58, 4'd6,  5'd23, 6'd59, 6'd0, 5'd0},  // R6 minute step
    {1'b1, 5'b11010, 8'd1,  4'd6,  5'd23, 6'd0,  6'd0, 5'd0},  // R6 wrap, no carry
    {1'b1, 5'b11010, 8'd59, 4'd6,  5'd23, 6'd59, 6'd0, 5'd0},  // R6
    {1'b1, 5'b10001, 8'd31, 4'd8,  5'd23, 6'd59, 6'd0, 5'd31}, // R8 day step
    {1'b0, 5'b00000, 8'd60, 4'd3,  5'd0,  6'd0,  6'd0, 5'd0},  // R3 day roll, R2 carries
    {1'b1, 5'b10001, 8'd5,  4'd8,  5'd0,  6'd0,  6'd0, 5'd5},  // R8
    {1'b1, 5'b11000, 8'd2,  4'd9,  5'd0,  6'd0,  6'd0, 5'd5},  // R9 no field picked
    {1'b1, 5'b01100, 8'd2,  4'd9,  5'd0,  6'd0,  6'd0, 5'd5},  // R9 not halted
    {1'b1, 5'b10000, 8'd2,  4'd9,  5'd0,  6'd0,  6'd0, 5'd5},  // R9 halted, no pick
    {1'b0, 5'b10001, 8'd4,  4'd4,  5'd0,  6'd0,  6'd0, 5'd5},  // R4 ticks while halted
    {1'b0, 5'b00000, 8'd1,  4'd1,  5'd0,  6'd0,  6'd1, 5'd5}   // R1 resumes
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) sec_tick = 1'b1;
    @(negedge clk) sec_tick = 1'b0;
  endtask

  task automatic do_press();
    @(negedge clk) bump_btn = 1'b1;
    repeat (3) @(negedge clk);
    bump_btn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_sw(input logic [4:0] sw);
    @(negedge clk);
    {halt_sw, settime_sw, pick_hr, pick_min, pick_day} = sw;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    {sec_tick, halt_sw, settime_sw, pick_hr, pick_min, pick_day, bump_btn} = '0;
    fmt24 = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 hour", hours_o, 0);
    chk("R11 min", minutes_o, 0);
    chk("R11 sec", seconds_o, 0);
    chk("R11 day", day_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      set_sw(v[38:34]);
      for (int k = 0; k < int'(v[33:26]); k++) begin
        if (v[39]) do_press();
        else       do_tick();
      end
      @(negedge clk);
      chk($sformatf("R%0d vec%0d hour", v[25:22], i), hours_o, v[21:17]);
      chk($sformatf("R%0d vec%0d min", v[25:22], i), minutes_o, v[16:11]);
      chk($sformatf("R%0d vec%0d sec", v[25:22], i), seconds_o, v[10:5]);
      chk($sformatf("R%0d vec%0d day", v[25:22], i), day_o, v[4:0]);
    end

    // R10 display format across the half-day boundary (hour is 0 here)
    set_sw(5'b11100);
    fmt24 = 1'b0;
    @(negedge clk) chk("R10 hour0 fold", disp_hr_o, 0);
    repeat (11) do_press();
    chk("R10 hour11 fold", disp_hr_o, 11);
    do_press();
    chk("R10 hour12 fold", disp_hr_o, 0);
    fmt24 = 1'b1;
    @(negedge clk) chk("R10 hour12 full", disp_hr_o, 12);
    do_press();
    fmt24 = 1'b0;
    @(negedge clk) chk("R10 hour13 fold", disp_hr_o, 1);
    repeat (10) do_press();
    chk("R10 hour23 fold", disp_hr_o, 11);

    // R9 long press counts once
    @(negedge clk) bump_btn = 1'b1;
    repeat (20) @(negedge clk);
    bump_btn = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 long press hour", hours_o, 0);

    // R11 reset in mid operation
    set_sw(5'b00000);
    repeat (7) do_tick();
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    chk("R11 mid sec", seconds_o, 0);
    chk("R11 mid day", day_o, 0);
    rst_n = 1'b1;
    do_tick();
    chk("R1 after reset", seconds_o, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule